// File: doc/BRIEF.md
# Duty-Ratio Tracking PWM Loop

This block is a digital control loop that makes a locally generated PWM waveform copy the mark/space ratio of an external pulse train. The external train may run at any frequency. The local waveform always runs at one fixed period of `PERIOD` clocks, which defaults to 1000. Only the number of high clocks per period, the mark length, is adjusted. The local waveform and the external signal feed an off-chip ratiometric comparator, which receives the local waveform through an inverting path. The comparator output is filtered and digitised into a 10-bit code. That code sits at mid-scale (512) when the two ratios are equal.

On each sample the block corrects the code by a stored offset. It then moves the mark length one count toward balance, at most once per PWM period. The mark length reported while `locked` is high is the measured duty ratio, in steps of 1/`PERIOD`. A calibration mode routes the local waveform to the second comparator path as well. In that mode the block records how far the code sits from 512 and subtracts that figure from every later reading.

The sample stream is valid-only. `adc_valid` marks a one-clock sample and there is no back-pressure, so the block accepts every sample that arrives while it is running. A sample that arrives while a mark update is not allowed still counts toward lock detection.

Top module: `duty_lock_loop`

## Requirements
- R1: After reset the mark length is `PERIOD`/2, the offset is 0, and `pwm_out`, `pwm_to_cmp` and `locked` are low.
- R2: The loop is running in a cycle when `start` was high at the previous clock edge. While running, a phase count steps through 0..`PERIOD`-1 and `pwm_out` is high exactly while the phase is below the mark length. While not running, `pwm_out` is low and the phase restarts at 0.
- R3: `pwm_to_cmp` equals `pwm_out` while `cal_mode` is high, and is low otherwise.
- R4: A normal sample is one with `adc_valid` high, the loop running and `cal_mode` low. Its deviation is `adc_code` − offset − 512. A deviation above +1 lowers the mark length by one. A deviation below −1 raises it by one. A deviation from −1 to +1 leaves it unchanged.
- R5: The mark length never leaves 1..`PERIOD`-1. A step that would cross a limit leaves the mark length at that limit.
- R6: After a sample that may move the mark length, no further move is taken until the phase has wrapped from `PERIOD`-1 to 0. Leaving the running state re-arms the update.
- R7: A sample with `adc_valid` high, the loop running and `cal_mode` high stores `adc_code` − 512 as the signed offset. Such a sample leaves the mark length unchanged. The offset changes at no other time.
- R8: `locked` rises after 8 consecutive normal samples with deviation in −1..+1. A normal sample outside that band clears it. `cal_mode` high or the loop not running also clears it, along with its count.
- R9: While the loop is not running, `adc_valid` has no effect on the mark length, the offset or `locked`.
- R10: With a comparator whose code rises with (mark length − input ratio), the mark length settles on the input ratio and `locked` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable; the loop runs one clock after it goes high |
| cal_mode | input | 1 | Calibration mode select |
| adc_valid | input | 1 | One-clock strobe marking a valid `adc_code` |
| adc_code | input | 10 | Sampled comparator code, mid-scale 512 at balance |
| pwm_out | output | 1 | Local PWM waveform, fed inverted to the comparator |
| pwm_to_cmp | output | 1 | Copy of the local PWM for the second comparator path during calibration |
| mark_len | output | 10 | Current mark length in clocks per period |
| offset | output | 11 | Signed stored comparator offset |
| locked | output | 1 | Mark length has settled inside the deadband |

## Verification
The bench drives the deadband edges, with deviations of ±1 that must hold and ±2 that must step. A design with an off-by-one band would hunt forever or stop one count early. It sends a second out-of-band sample within the same PWM period to catch loops that chase ripple and step several times per period. It drives targets beyond both ends of the range to expose a mark length that wraps past 1 or `PERIOD`-1. It checks that an offset stored during calibration shifts the balance point, and that samples arriving while stopped or calibrating leave the mark length and lock state alone.

// File: rtl/dll_pkg.sv
package dll_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/dll_pwm_gen.sv
module dll_pwm_gen #(
  parameter int PERIOD = 1000,
  parameter int MARK_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MARK_W-1:0] mark,
  output logic              run,
  output logic              wrap,
  output logic              pwm
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             run_q;
  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      run_q <= start;
      if (!run_q || phase_q == LAST) phase_q <= '0;
      else                           phase_q <= phase_q + 1'b1;
    end
  end

  assign run  = run_q;
  assign wrap = run_q && (phase_q == LAST);
  assign pwm  = run_q && (MARK_W'(phase_q) < mark);

  // R2: mark length is at least one, so every period opens high
  p_first_tick_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && phase_q == '0) |-> pwm);
  // R2: phase restarts after the loop stops
  p_phase_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (phase_q == '0));
endmodule

// File: rtl/dll_err_eval.sv
module dll_err_eval
  import dll_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int DEADBAND = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     cal_mode,
  input  logic                     adc_valid,
  input  logic [CODE_W-1:0]        adc_code,
  output logic signed [CODE_W:0]   offset,
  output logic                     samp,
  output step_e                    step
);
  localparam int OFF_W = CODE_W + 1;
  localparam int DEV_W = CODE_W + 2;
  localparam int MID   = 1 << (CODE_W - 1);
  localparam logic signed [DEV_W-1:0] MID_D = DEV_W'(MID);
  localparam logic signed [OFF_W-1:0] MID_O = OFF_W'(MID);
  localparam logic signed [DEV_W-1:0] DB_D  = DEV_W'(DEADBAND);

  logic signed [OFF_W-1:0] offset_q;
  logic signed [DEV_W-1:0] dev;
  logic                    cal_take;

  assign cal_take = adc_valid && run && cal_mode;
  assign samp     = adc_valid && run && !cal_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        offset_q <= '0;
    else if (cal_take) offset_q <= $signed({1'b0, adc_code}) - MID_O;
  end

  always_comb begin
    dev = $signed({2'b00, adc_code}) - MID_D - {offset_q[OFF_W-1], offset_q};
    if (dev > DB_D)       step = STEP_DOWN;
    else if (dev < -DB_D) step = STEP_UP;
    else                  step = STEP_HOLD;
  end

  assign offset = offset_q;

  // R7: offset only moves on a calibration sample
  p_offset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_mode) |-> (offset_q == $past(offset_q)));
  // R9: no offset capture while stopped
  p_offset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (offset_q == $past(offset_q)));
endmodule

// File: rtl/dll_mark_ctrl.sv
module dll_mark_ctrl
  import dll_pkg::*;
#(
  parameter int PERIOD = 1000,
  parameter int MARK_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic              samp,
  input  step_e             step,
  output logic [MARK_W-1:0] mark
);
  localparam logic [MARK_W-1:0] MIN_M  = MARK_W'(1);
  localparam logic [MARK_W-1:0] MAX_M  = MARK_W'(PERIOD - 1);
  localparam logic [MARK_W-1:0] INIT_M = MARK_W'(PERIOD / 2);

  logic [MARK_W-1:0] mark_q;
  logic              upd_ok_q;
  logic              apply;

  assign apply = samp && (step != STEP_HOLD) && upd_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q   <= INIT_M;
      upd_ok_q <= 1'b1;
    end else begin
      if (!run || wrap) upd_ok_q <= 1'b1;
      else if (apply)   upd_ok_q <= 1'b0;
      if (apply) begin
        if (step == STEP_UP && mark_q < MAX_M)        mark_q <= mark_q + 1'b1;
        else if (step == STEP_DOWN && mark_q > MIN_M) mark_q <= mark_q - 1'b1;
      end
    end
  end

  assign mark = mark_q;

  // R5: mark length stays in its legal range
  p_mark_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q >= MIN_M) && (mark_q <= MAX_M));
  // R4: a move is a single count
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q != $past(mark_q)) |->
      ((mark_q == $past(mark_q) + 1'b1) || (mark_q == $past(mark_q) - 1'b1)));
  // R4: an in-band sample leaves the mark length alone
  p_hold_in_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp && step == STEP_HOLD) |=> (mark_q == $past(mark_q)));
  // R6: no second move before the phase wraps
  p_once_per_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ok_q && !wrap && run) |=> (mark_q == $past(mark_q)));
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
  import dll_pkg::*;
#(
  parameter int LOCK_N = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  cal_mode,
  input  logic  samp,
  input  step_e step,
  output logic  locked
);
  localparam int CW = $clog2(LOCK_N + 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_N);

  logic [CW-1:0] hits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hits_q <= '0;
    else if (!run || cal_mode) hits_q <= '0;
    else if (samp) begin
      if (step != STEP_HOLD) hits_q <= '0;
      else if (hits_q != FULL) hits_q <= hits_q + 1'b1;
    end
  end

  assign locked = (hits_q == FULL);

  // R8: an out-of-band sample drops lock
  p_drop_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (samp && step != STEP_HOLD) |=> !locked);
  // R8: calibration or stop drops lock
  p_drop_on_cal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode || !run) |=> !locked);
endmodule

// File: rtl/duty_lock_loop.sv
module duty_lock_loop
  import dll_pkg::*;
#(
  parameter int PERIOD   = 1000,
  parameter int MARK_W   = 10,
  parameter int CODE_W   = 10,
  parameter int DEADBAND = 1,
  parameter int LOCK_N   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   cal_mode,
  input  logic                   adc_valid,
  input  logic [CODE_W-1:0]      adc_code,
  output logic                   pwm_out,
  output logic                   pwm_to_cmp,
  output logic [MARK_W-1:0]      mark_len,
  output logic signed [CODE_W:0] offset,
  output logic                   locked
);
  logic  run;
  logic  wrap;
  logic  pwm;
  logic  samp;
  step_e step;
  logic [MARK_W-1:0] mark;

  dll_pwm_gen #(.PERIOD(PERIOD), .MARK_W(MARK_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .start(start), .mark(mark),
    .run(run), .wrap(wrap), .pwm(pwm)
  );

  dll_err_eval #(.CODE_W(CODE_W), .DEADBAND(DEADBAND)) u_err (
    .clk(clk), .rst_n(rst_n), .run(run), .cal_mode(cal_mode),
    .adc_valid(adc_valid), .adc_code(adc_code),
    .offset(offset), .samp(samp), .step(step)
  );

  dll_mark_ctrl #(.PERIOD(PERIOD), .MARK_W(MARK_W)) u_mark (
    .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap),
    .samp(samp), .step(step), .mark(mark)
  );

  dll_lock_det #(.LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(run), .cal_mode(cal_mode),
    .samp(samp), .step(step), .locked(locked)
  );

  assign pwm_out    = pwm;
  assign pwm_to_cmp = cal_mode && pwm;
  assign mark_len   = mark;

  // R3: second comparator path is quiet outside calibration
  p_cal_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode |-> !pwm_to_cmp);
  // R7: calibration samples do not move the mark length
  p_cal_no_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_mode) |-> (mark_len == $past(mark_len)));
  // R9: samples while stopped do not move the mark length
  p_idle_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start, 2) |-> (mark_len == $past(mark_len)));
endmodule

// File: tb/duty_lock_loop_tb_top.sv
`timescale 1ns/1ps
module duty_lock_loop_tb_top;
  localparam int P     = 100;
  localparam int OFFT  = 3;
  localparam int WDOG  = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cal_mode = 1'b0;
  logic       adc_valid = 1'b0;
  logic [9:0] adc_code = '0;
  logic       pwm_out, pwm_to_cmp, locked;
  logic [9:0] mark_len;
  logic signed [10:0] offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit auto_en = 1'b0;
  int target = 60;
  int gap = 0;

  // behavioural reference state
  int m_mark = P / 2, m_off = 0, m_cnt = 0, m_hits = 0;
  bit m_run = 1'b0, m_upd = 1'b1;

  always #10 clk = ~clk;

  duty_lock_loop #(.PERIOD(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode),
    .adc_valid(adc_valid), .adc_code(adc_code), .pwm_out(pwm_out),
    .pwm_to_cmp(pwm_to_cmp), .mark_len(mark_len), .offset(offset),
    .locked(locked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mark = P / 2; m_off = 0; m_cnt = 0; m_hits = 0; m_run = 0; m_upd = 1;
    end else begin
      bit acc, calacc, wrap, apply;
      int dev, nmark, nhits, noff, ncnt;
      bit nupd;
      acc    = adc_valid && m_run && !cal_mode;
      calacc = adc_valid && m_run && cal_mode;
      dev    = int'(adc_code) - m_off - 512;
      wrap   = m_run && (m_cnt == P - 1);
      apply  = acc && (dev > 1 || dev < -1) && m_upd;
      nmark  = m_mark;
      if (apply) begin
        if (dev > 1 && m_mark > 1) nmark = m_mark - 1;
        else if (dev < -1 && m_mark < P - 1) nmark = m_mark + 1;
      end
      nupd  = (!m_run || wrap) ? 1'b1 : (apply ? 1'b0 : m_upd);
      nhits = m_hits;
      if (!m_run || cal_mode) nhits = 0;
      else if (acc) nhits = (dev >= -1 && dev <= 1) ? ((m_hits < 8) ? m_hits + 1 : 8) : 0;
      noff = calacc ? int'(adc_code) - 512 : m_off;
      ncnt = (!m_run || wrap) ? 0 : m_cnt + 1;
      m_mark = nmark; m_upd = nupd; m_hits = nhits; m_off = noff; m_cnt = ncnt;
      m_run = start;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit epwm;
      epwm = m_run && (m_cnt < m_mark);
      check(pwm_out == epwm, "R2 pwm_out", int'(pwm_out), int'(epwm));
      check(pwm_to_cmp == (cal_mode && epwm), "R3 pwm_to_cmp", int'(pwm_to_cmp),
            int'(cal_mode && epwm));
      check(int'(mark_len) == m_mark, "R4 mark_len", int'(mark_len), m_mark);
      check(int'(offset) == m_off, "R7 offset", int'(offset), m_off);
      check(locked == (m_hits == 8), "R8 locked", int'(locked), int'(m_hits == 8));
    end
  end

  // comparator and converter model: code rises with (mark - target)
  always @(posedge clk) begin
    #1;
    if (auto_en) begin
      gap++;
      if (gap >= 7) begin
        int c;
        gap = 0;
        if (cal_mode) c = 512 + OFFT;
        else c = 512 + 4 * (int'(mark_len) - target) + OFFT;
        if (c < 0) c = 0;
        if (c > 1023) c = 1023;
        adc_valid = 1'b1;
        adc_code  = 10'(c);
      end else begin
        adc_valid = 1'b0;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic one_sample(input int code);
    @(posedge clk); #1;
    adc_valid = 1'b1; adc_code = 10'(code);
    @(posedge clk); #1;
    adc_valid = 1'b0;
  endtask

  initial begin
    cycles(WDOG);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_sim();
  end

  initial begin
    cycles(3); #1 rst_n = 1'b1;
    @(negedge clk);
    check(int'(mark_len) == P / 2, "R1 reset mark", int'(mark_len), P / 2);
    check(int'(offset) == 0, "R1 reset offset", int'(offset), 0);
    check(!pwm_out && !pwm_to_cmp, "R1 reset pwm", int'(pwm_out), 0);
    check(!locked, "R1 reset locked", int'(locked), 0);

    // calibration
    @(posedge clk); #1; start = 1'b1; cal_mode = 1'b1; auto_en = 1'b1;
    cycles(40);
    @(negedge clk);
    check(int'(offset) == OFFT, "R7 stored offset", int'(offset), OFFT);
    check(int'(mark_len) == P / 2, "R7 mark kept in cal", int'(mark_len), P / 2);
    check(!locked, "R8 no lock in cal", int'(locked), 0);

    // tracking toward 60
    @(posedge clk); #1; cal_mode = 1'b0; target = 60;
    cycles(3000);
    @(negedge clk);
    check(int'(mark_len) == 60, "R10 settled mark", int'(mark_len), 60);
    check(locked, "R10 R8 locked", int'(locked), 1);
    check(!pwm_to_cmp, "R3 quiet path", int'(pwm_to_cmp), 0);

    // deadband edges and once-per-period gate
    @(posedge clk); #1; auto_en = 1'b0; adc_valid = 1'b0;
    cycles(2 * P);
    one_sample(512 + OFFT + 2);
    @(negedge clk);
    check(int'(mark_len) == 59, "R4 dev +2 steps down", int'(mark_len), 59);
    check(!locked, "R8 miss clears lock", int'(locked), 0);
    cycles(2 * P);
    one_sample(512 + OFFT + 1);
    @(negedge clk);
    check(int'(mark_len) == 59, "R4 dev +1 holds", int'(mark_len), 59);
    one_sample(512 + OFFT - 1);
    @(negedge clk);
    check(int'(mark_len) == 59, "R4 dev -1 holds", int'(mark_len), 59);
    one_sample(512 + OFFT - 2);
    @(negedge clk);
    check(int'(mark_len) == 60, "R4 dev -2 steps up", int'(mark_len), 60);
    one_sample(512 + OFFT - 2);
    @(negedge clk);
    check(int'(mark_len) == 60, "R6 second move blocked", int'(mark_len), 60);

    // saturation at both ends
    @(posedge clk); #1; auto_en = 1'b1; target = 150;
    cycles(6000);
    @(negedge clk);
    check(int'(mark_len) == P - 1, "R5 upper limit", int'(mark_len), P - 1);
    @(posedge clk); #1; target = -60;
    cycles(11000);
    @(negedge clk);
    check(int'(mark_len) == 1, "R5 lower limit", int'(mark_len), 1);

    // stopped: samples ignored
    @(posedge clk); #1; auto_en = 1'b0; adc_valid = 1'b0; start = 1'b0;
    cycles(3);
    one_sample(900);
    @(negedge clk);
    check(int'(mark_len) == 1, "R9 mark unchanged while stopped", int'(mark_len), 1);
    check(int'(offset) == OFFT, "R9 offset unchanged while stopped", int'(offset), OFFT);
    check(!locked, "R9 no lock while stopped", int'(locked), 0);
    check(!pwm_out, "R2 pwm low while stopped", int'(pwm_out), 0);
    cycles(5);
    finish_sim();
  end
endmodule